// File: doc/BRIEF.md
# Window Watchdog with Register-Write Service

This block supervises a host by requiring a periodic service command inside a timed window. After every service the watchdog opens a closed window, during which servicing is forbidden, and then an open window, during which the host must service. The service is not a strobe. It is a register write with a fixed address and data value, arriving on a simple command port alongside any other register traffic.

Time is measured in ticks from a shared time-base input. The closed window and the open window each count their own unit size in ticks, set by parameters. Their unit counts come from configuration inputs. Servicing too early, or failing to service before the open window runs out, raises a 7-bit error count. A correct service lowers the count. When the count reaches a parameter limit, the block issues a single-cycle reset request and latches a window-watchdog reset-cause flag.

Top module: `win_wdog`

## Requirements
- R1: After rst_ni is asserted, err_cnt_o is 0, win_open_o is 0 (closed window), rst_cause_o is 0 and rst_req_o is 0.
- R2: Only a command with cmd_valid_i=1, cmd_addr_i=7'h15 and cmd_wdata_i=8'h03 is a service. A write with any other address or data has no effect on err_cnt_o or on window timing.
- R3: The closed window lasts cfg_closed_units_i × CLOSED_BASE ticks, after which win_open_o becomes 1. A unit count of 0 behaves as 1.
- R4: The open window lasts cfg_open_units_i × OPEN_BASE ticks. A unit count of 0 behaves as 1.
- R5: A service while win_open_o=0 raises err_cnt_o by one and restarts the closed window from zero.
- R6: A service while win_open_o=1 lowers err_cnt_o by one, saturating at 0, and starts a new closed window.
- R7: An open window that ends without a service raises err_cnt_o by one and starts a new closed window. A service in the same cycle as the final open tick counts as a correct service.
- R8: An error event that would bring err_cnt_o to ERR_LIMIT instead clears err_cnt_o to 0, pulses rst_req_o high for exactly one cycle and sets rst_cause_o. rst_cause_o stays set until rst_ni.
- R9: Cycles with tick_i=0 do not advance either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick, one-cycle qualifier |
| cfg_closed_units_i | input | CL_UNITS_W (6) | Closed window length in closed-window units |
| cfg_open_units_i | input | OP_UNITS_W (4) | Open window length in open-window units |
| cmd_valid_i | input | 1 | Register write strobe |
| cmd_addr_i | input | ADDR_W (7) | Register write address |
| cmd_wdata_i | input | DATA_W (8) | Register write data |
| err_cnt_o | output | ERR_W (7) | Window error counter |
| win_open_o | output | 1 | 1 while the open window is running |
| rst_cause_o | output | 1 | Sticky flag: reset caused by this watchdog |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is a service that lands on the very tick where the open window would expire, because the service must win over the expiry. The bench reaches it with a directed sequence. It uses the shortest unit counts, counts exactly the open-window ticks up to the last one, and issues the service together with that tick. Reaching the error limit relies on back-to-back early services. Long random runs change the unit counts between windows and thin out the ticks, so services fall at every position inside both windows.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    PH_CLOSED = 1'b0,
    PH_OPEN   = 1'b1
  } phase_e;

  localparam logic [6:0] SVC_ADDR_DEF = 7'h15;
  localparam logic [7:0] SVC_DATA_DEF = 8'h03;
endpackage

// File: rtl/wdog_cmd_dec.sv
module wdog_cmd_dec
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(SVC_ADDR_DEF),
  parameter logic [DATA_W-1:0] SVC_DATA = DATA_W'(SVC_DATA_DEF)
) (
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  phase_e            phase_i,
  output logic              svc_o,
  output logic              svc_ok_o,
  output logic              svc_early_o
);
  always_comb begin
    svc_o       = cmd_valid_i && (cmd_addr_i == SVC_ADDR) && (cmd_wdata_i == SVC_DATA);
    svc_ok_o    = svc_o && (phase_i == PH_OPEN);
    svc_early_o = svc_o && (phase_i == PH_CLOSED);
  end
endmodule

// File: rtl/wdog_win_timer.sv
module wdog_win_timer
  import wdog_pkg::*;
#(
  parameter int CLOSED_BASE = 16,
  parameter int OPEN_BASE   = 32,
  parameter int CL_UNITS_W  = 6,
  parameter int OP_UNITS_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  restart_i,
  input  logic [CL_UNITS_W-1:0] closed_units_i,
  input  logic [OP_UNITS_W-1:0] open_units_i,
  output phase_e                phase_o,
  output logic                  expire_o
);
  localparam int MAX_BASE = (CLOSED_BASE > OPEN_BASE) ? CLOSED_BASE : OPEN_BASE;
  localparam int PRE_W    = $clog2(MAX_BASE + 1);
  localparam int UNIT_W   = (CL_UNITS_W > OP_UNITS_W) ? CL_UNITS_W : OP_UNITS_W;

  phase_e            phase_q;
  logic [PRE_W-1:0]  pre_q;
  logic [UNIT_W-1:0] unit_q;
  logic [PRE_W-1:0]  base_m1;
  logic [UNIT_W-1:0] units_lim, units_m1;
  logic              unit_end, win_end;

  always_comb begin
    if (phase_q == PH_OPEN) begin
      base_m1   = PRE_W'(OPEN_BASE - 1);
      units_lim = UNIT_W'(open_units_i);
    end else begin
      base_m1   = PRE_W'(CLOSED_BASE - 1);
      units_lim = UNIT_W'(closed_units_i);
    end
    // zero units behaves as one
    units_m1 = (units_lim == '0) ? '0 : units_lim - 1'b1;
    unit_end = tick_i && (pre_q == base_m1);
    // >= so a shrunk config ends the window at the next unit boundary
    win_end  = unit_end && (unit_q >= units_m1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CLOSED;
      pre_q   <= '0;
      unit_q  <= '0;
    end else if (restart_i) begin
      phase_q <= PH_CLOSED;
      pre_q   <= '0;
      unit_q  <= '0;
    end else if (win_end) begin
      phase_q <= (phase_q == PH_CLOSED) ? PH_OPEN : PH_CLOSED;
      pre_q   <= '0;
      unit_q  <= '0;
    end else if (unit_end) begin
      pre_q  <= '0;
      unit_q <= unit_q + 1'b1;
    end else if (tick_i) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign phase_o  = phase_q;
  // a service on the final tick has priority over expiry
  assign expire_o = win_end && (phase_q == PH_OPEN) && !restart_i;
endmodule

// File: rtl/wdog_err_ctrl.sv
module wdog_err_ctrl #(
  parameter int ERR_W     = 7,
  parameter int ERR_LIMIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_evt_i,
  input  logic             svc_ok_i,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic             rst_cause_o,
  output logic             rst_req_o
);
  localparam logic [ERR_W:0] LIMIT = (ERR_W+1)'(ERR_LIMIT);

  logic [ERR_W-1:0] err_q;
  logic             cause_q, req_q;
  logic [ERR_W:0]   err_inc;

  assign err_inc = {1'b0, err_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      cause_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (err_evt_i) begin
        if (err_inc >= LIMIT) begin
          err_q   <= '0;
          req_q   <= 1'b1;
          cause_q <= 1'b1;
        end else begin
          err_q <= err_inc[ERR_W-1:0];
        end
      end else if (svc_ok_i && (err_q != '0)) begin
        err_q <= err_q - 1'b1;
      end
    end
  end

  assign err_cnt_o   = err_q;
  assign rst_cause_o = cause_q;
  assign rst_req_o   = req_q;
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(SVC_ADDR_DEF),
  parameter logic [DATA_W-1:0] SVC_DATA = DATA_W'(SVC_DATA_DEF),
  parameter int CLOSED_BASE = 16,
  parameter int OPEN_BASE   = 32,
  parameter int CL_UNITS_W  = 6,
  parameter int OP_UNITS_W  = 4,
  parameter int ERR_W       = 7,
  parameter int ERR_LIMIT   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [CL_UNITS_W-1:0] cfg_closed_units_i,
  input  logic [OP_UNITS_W-1:0] cfg_open_units_i,
  input  logic                  cmd_valid_i,
  input  logic [ADDR_W-1:0]     cmd_addr_i,
  input  logic [DATA_W-1:0]     cmd_wdata_i,
  output logic [ERR_W-1:0]      err_cnt_o,
  output logic                  win_open_o,
  output logic                  rst_cause_o,
  output logic                  rst_req_o
);
  phase_e phase;
  logic   svc, svc_ok, svc_early, expire;

  wdog_cmd_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .SVC_DATA(SVC_DATA)
  ) u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .phase_i     (phase),
    .svc_o       (svc),
    .svc_ok_o    (svc_ok),
    .svc_early_o (svc_early)
  );

  wdog_win_timer #(
    .CLOSED_BASE(CLOSED_BASE), .OPEN_BASE(OPEN_BASE),
    .CL_UNITS_W(CL_UNITS_W), .OP_UNITS_W(OP_UNITS_W)
  ) u_tmr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .restart_i      (svc),
    .closed_units_i (cfg_closed_units_i),
    .open_units_i   (cfg_open_units_i),
    .phase_o        (phase),
    .expire_o       (expire)
  );

  wdog_err_ctrl #(
    .ERR_W(ERR_W), .ERR_LIMIT(ERR_LIMIT)
  ) u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_evt_i   (svc_early | expire),
    .svc_ok_i    (svc_ok),
    .err_cnt_o   (err_cnt_o),
    .rst_cause_o (rst_cause_o),
    .rst_req_o   (rst_req_o)
  );

  assign win_open_o = (phase == PH_OPEN);
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 7'h15,
  parameter logic [DATA_W-1:0] SVC_DATA = 8'h03,
  parameter int ERR_W     = 7,
  parameter int ERR_LIMIT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              cmd_valid_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic [DATA_W-1:0] cmd_wdata_i,
  input logic [ERR_W-1:0]  err_cnt_o,
  input logic              win_open_o,
  input logic              rst_cause_o,
  input logic              rst_req_o
);
  logic svc_seen;
  assign svc_seen = cmd_valid_i && (cmd_addr_i == SVC_ADDR) && (cmd_wdata_i == SVC_DATA);

  p_req_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  p_req_with_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rst_cause_o);

  p_cause_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cause_o |=> rst_cause_o);

  p_err_below_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ERR_W+1)'(err_cnt_o) < (ERR_W+1)'(ERR_LIMIT));

  p_early_counts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_seen && !win_open_o) |=>
      (rst_req_o || ((ERR_W+1)'(err_cnt_o) == (ERR_W+1)'($past(err_cnt_o)) + 1'b1)));

  p_good_service_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_seen && win_open_o) |=> (!win_open_o && (err_cnt_o <= $past(err_cnt_o))));

  p_no_tick_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !svc_seen) |=> ($stable(win_open_o) && $stable(err_cnt_o)));
endmodule

bind win_wdog win_wdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .SVC_DATA(SVC_DATA),
  .ERR_W(ERR_W), .ERR_LIMIT(ERR_LIMIT)
) u_chk (.*);

// File: tb/win_wdog_test.sv
`timescale 1ns/1ps
module win_wdog_test;
  localparam int CB = 16, OB = 32, LIM = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [5:0] cfg_closed_units_i = 6'd2;
  logic [3:0] cfg_open_units_i = 4'd1;
  logic       cmd_valid_i = 1'b0;
  logic [6:0] cmd_addr_i = '0;
  logic [7:0] cmd_wdata_i = '0;
  logic [6:0] err_cnt_o;
  logic       win_open_o, rst_cause_o, rst_req_o;

  always #5 clk = ~clk;

  win_wdog uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .cfg_closed_units_i(cfg_closed_units_i), .cfg_open_units_i(cfg_open_units_i),
    .cmd_valid_i(cmd_valid_i), .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i),
    .err_cnt_o(err_cnt_o), .win_open_o(win_open_o),
    .rst_cause_o(rst_cause_o), .rst_req_o(rst_req_o)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  bit m_open, m_cause, m_req;
  int m_ticks, m_err;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int u);
    return (u == 0) ? 1 : u;
  endfunction

  task automatic m_error();
    if (m_err + 1 >= LIM) begin m_err = 0; m_req = 1; m_cause = 1; end
    else m_err = m_err + 1;
  endtask

  task automatic m_step(input bit t, input bit svc);
    int base, units;
    m_req = 0;
    base  = m_open ? OB : CB;
    units = m_open ? eff(int'(cfg_open_units_i)) : eff(int'(cfg_closed_units_i));
    if (svc) begin
      if (m_open) begin if (m_err > 0) m_err = m_err - 1; end
      else m_error();
      m_open = 0; m_ticks = 0;
    end else if (t) begin
      if (((m_ticks + 1) % base == 0) && ((m_ticks + 1) / base >= units)) begin
        if (m_open) m_error();
        m_open = !m_open; m_ticks = 0;
      end else m_ticks = m_ticks + 1;
    end
  endtask

  task automatic cyc(input bit t, input bit v, input logic [6:0] a, input logic [7:0] d,
                     input string tag);
    tick_i = t; cmd_valid_i = v; cmd_addr_i = a; cmd_wdata_i = d;
    m_step(t, v && a == 7'h15 && d == 8'h03);
    @(posedge clk); @(negedge clk);
    check(int'(err_cnt_o) == m_err, tag, int'(err_cnt_o), m_err);
    check(win_open_o == m_open, tag, int'(win_open_o), int'(m_open));
    check(rst_cause_o == m_cause, tag, int'(rst_cause_o), int'(m_cause));
    check(rst_req_o == m_req, tag, int'(rst_req_o), int'(m_req));
  endtask

  task automatic idle(input bit t, input string tag);
    cyc(t, 1'b0, 7'h00, 8'h00, tag);
  endtask

  task automatic service(input string tag);
    cyc(1'b1, 1'b1, 7'h15, 8'h03, tag);
  endtask

  task automatic do_reset();
    rst_ni = 0; tick_i = 0; cmd_valid_i = 0;
    repeat (3) @(negedge clk);
    m_open = 0; m_cause = 0; m_req = 0; m_ticks = 0; m_err = 0;
    rst_ni = 1;
    @(negedge clk);
    check(err_cnt_o == 0, "R1 err", int'(err_cnt_o), 0);
    check(win_open_o == 0, "R1 open", int'(win_open_o), 0);
    check(rst_cause_o == 0, "R1 cause", int'(rst_cause_o), 0);
    check(rst_req_o == 0, "R1 req", int'(rst_req_o), 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'h00c0ffee));
    @(negedge clk);

    // R3: closed window length, 2 units
    cfg_closed_units_i = 6'd2; cfg_open_units_i = 4'd1;
    do_reset();
    n = 0;
    while (!win_open_o && n < 200) begin idle(1'b1, "R3"); n++; end
    check(n == 2 * CB, "R3 closed length", n, 2 * CB);

    // R4: open window length, 1 unit; expiry counts error (R7)
    n = 0;
    while (win_open_o && n < 200) begin idle(1'b1, "R4"); n++; end
    check(n == OB, "R4 open length", n, OB);
    check(err_cnt_o == 1, "R7 expiry error", int'(err_cnt_o), 1);

    // R3: zero units behave as one
    cfg_closed_units_i = 6'd0;
    do_reset();
    n = 0;
    while (!win_open_o && n < 200) begin idle(1'b1, "R3"); n++; end
    check(n == CB, "R3 zero units", n, CB);

    // R6: good service at err 0 saturates
    service("R6");
    check(err_cnt_o == 0 && !win_open_o, "R6 saturate", int'(err_cnt_o), 0);

    // R2: near-miss writes ignored, closed window not restarted
    cfg_closed_units_i = 6'd1;
    do_reset();
    repeat (5) idle(1'b1, "R2");
    cyc(1'b1, 1'b1, 7'h15, 8'h02, "R2");
    cyc(1'b1, 1'b1, 7'h16, 8'h03, "R2");
    cyc(1'b1, 1'b0, 7'h15, 8'h03, "R2");
    check(err_cnt_o == 0, "R2 err untouched", int'(err_cnt_o), 0);
    repeat (CB - 9) idle(1'b1, "R2");
    check(win_open_o == 0, "R2 timing before", int'(win_open_o), 0);
    idle(1'b1, "R2");
    check(win_open_o == 1, "R2 timing kept", int'(win_open_o), 1);

    // R5: early service counts and restarts closed window
    do_reset();
    repeat (10) idle(1'b1, "R5");
    service("R5");
    check(err_cnt_o == 1, "R5 early error", int'(err_cnt_o), 1);
    repeat (CB - 1) idle(1'b1, "R5");
    check(win_open_o == 0, "R5 restart", int'(win_open_o), 0);
    idle(1'b1, "R5");
    check(win_open_o == 1, "R5 reopen", int'(win_open_o), 1);

    // R9: no ticks, no progress
    repeat (100) idle(1'b0, "R9");
    check(win_open_o == 1 && err_cnt_o == 1, "R9 hold", int'(win_open_o), 1);

    // R7: service on the final open tick wins over expiry
    repeat (OB - 1) idle(1'b1, "R7");
    check(win_open_o == 1, "R7 still open", int'(win_open_o), 1);
    service("R7");
    check(err_cnt_o == 0 && !win_open_o, "R7 priority", int'(err_cnt_o), 0);

    // R8: reaching the limit
    do_reset();
    for (int i = 0; i < LIM - 1; i++) service("R8");
    check(err_cnt_o == LIM - 1 && !rst_req_o, "R8 below", int'(err_cnt_o), LIM - 1);
    service("R8");
    check(rst_req_o == 1, "R8 req", int'(rst_req_o), 1);
    check(err_cnt_o == 0, "R8 clear", int'(err_cnt_o), 0);
    idle(1'b1, "R8");
    check(rst_req_o == 0 && rst_cause_o == 1, "R8 pulse/sticky", int'(rst_req_o), 0);

    // random traffic against the model
    do_reset();
    for (int i = 0; i < 30000; i++) begin
      int r;
      bit t;
      if ($urandom_range(0, 499) == 0) begin
        cfg_closed_units_i = 6'($urandom_range(0, 3));
        cfg_open_units_i   = 4'($urandom_range(0, 2));
      end
      t = ($urandom_range(0, 9) < 7);
      r = $urandom_range(0, 39);
      if (r == 0) cyc(t, 1'b1, 7'h15, 8'h03, m_open ? "R6" : "R5");
      else if (r == 1) cyc(t, 1'b1, 7'h15, 8'($urandom_range(4, 255)), "R2");
      else if (r == 2) cyc(t, 1'b1, 7'($urandom_range(22, 127)), 8'h03, "R2");
      else cyc(t, 1'b0, 7'($urandom), 8'($urandom), "R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule